// File: doc/BRIEF.md
# Conduction Mode Arbiter with Sign Debounce

This block decides, one switching cycle at a time, whether a synchronous buck controller runs fixed-frequency PWM in continuous conduction or variable-frequency hysteretic control with the low-side switch acting as a diode. Once per switching cycle, just before the high-side switch closes, the polarity of the voltage across the synchronous switch is presented on `smp_pos` with a one-cycle strobe `smp_vld`. A positive polarity says the load sits above the critical inductor current; a negative polarity says it sits below.

A mode change is only taken after a run of `RUN_LEN` (default eight) samples of the same polarity that points away from the present mode, so that a noisy sign near the critical current cannot make the converter chatter. Continuous conduction is imposed whenever hysteretic operation is disabled by `hyst_en` being low, and for as long as the reference controller reports a voltage transition on `ref_slewing`. In hysteretic mode the block also produces the on/off request from the two window comparators: a pulse begins when the output falls below the lower threshold and ends when it rises over the upper one.

Top module: `cond_mode_arbiter`

## Requirements
- R1: After reset the block is in continuous conduction: `mode_hyst` = 0, `diode_emu_en` = 0, `hyst_pulse_req` = 0.
- R2: In continuous mode with no forcing active, the clock edge that accepts the `RUN_LEN`-th consecutive strobed sample with `smp_pos` = 0 sets `mode_hyst` to 1; a run of `RUN_LEN`-1 such samples leaves it at 0.
- R3: In hysteretic mode with no forcing active, the edge that accepts the `RUN_LEN`-th consecutive strobed sample with `smp_pos` = 1 returns `mode_hyst` to 0.
- R4: A strobed sample whose polarity differs from the current run starts a new run of length one.
- R5: Cycles with `smp_vld` = 0 neither extend nor break a run.
- R6: While `hyst_en` = 0, the edge that sees it leaves `mode_hyst` = 0 and clears the run.
- R7: While `ref_slewing` = 1, the edge that sees it leaves `mode_hyst` = 0 and clears the run.
- R8: `diode_emu_en` equals `mode_hyst` on every cycle.
- R9: In hysteretic mode `hyst_pulse_req` is set by an edge with `cmp_below_lo` = 1, cleared by an edge with `cmp_above_hi` = 1 (clear wins when both are 1), and held otherwise.
- R10: `hyst_pulse_req` is 0 whenever `mode_hyst` is 0, including after the edge that leaves hysteretic mode.
- R11: Every mode change clears the run, so a further change needs a full new run of `RUN_LEN` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Strobe: a polarity sample is present this cycle |
| smp_pos | input | 1 | Sample polarity: 1 = positive (above critical), 0 = negative |
| hyst_en | input | 1 | 1 allows hysteretic mode; 0 forces continuous conduction |
| ref_slewing | input | 1 | 1 while the reference is moving; forces continuous conduction |
| cmp_below_lo | input | 1 | Output is below the lower hysteretic threshold |
| cmp_above_hi | input | 1 | Output is above the upper hysteretic threshold |
| mode_hyst | output | 1 | 1 = hysteretic, 0 = continuous conduction |
| diode_emu_en | output | 1 | Low-side driver blocks reverse current |
| hyst_pulse_req | output | 1 | Hysteretic high-side on request |

## Verification
On every cycle the assertions check that the run length stays bounded, that the mode only moves on a completed run or under forcing, that either forcing input leaves continuous mode on the next edge, that a mode change leaves an empty run, that the upper comparator always ends a pulse and that no pulse exists outside hysteretic mode. Whether a run of exactly `RUN_LEN` samples is needed, that a disagreeing sample restarts at one rather than zero, that idle cycles are transparent and that a run in progress is discarded at a mode change can only be shown by the bench's sample sequences compared against its own model.

// File: rtl/cond_mode_pkg.sv
package cond_mode_pkg;
  typedef enum logic {
    MODE_CCM  = 1'b0,
    MODE_HYST = 1'b1
  } arb_mode_e;

  // Next run length after a strobed sample: extend a matching run up to lim,
  // otherwise begin a new run of one.
  function automatic int unsigned run_next(int unsigned cnt, logic same, int unsigned lim);
    if (same && cnt != 0) return (cnt < lim) ? cnt + 1 : lim;
    return 1;
  endfunction
endpackage

// File: rtl/arb_sign_run.sv
module arb_sign_run #(
  parameter int RUN_LEN = 8,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic             smp_pos,
  input  logic             clr,
  output logic             run_done,
  output logic [CNT_W-1:0] run_cnt
);
  import cond_mode_pkg::*;

  logic             sign_q;
  logic [CNT_W-1:0] cnt_q;
  logic             same;

  assign same     = (smp_pos == sign_q) && (cnt_q != '0);
  assign run_done = smp_vld && same && (cnt_q == CNT_W'(RUN_LEN - 1));
  assign run_cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sign_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
    end else if (smp_vld) begin
      cnt_q  <= CNT_W'(run_next(int'(cnt_q), same, RUN_LEN));
      sign_q <= smp_pos;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RUN_LEN));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/arb_mode_fsm.sv
module arb_mode_fsm
  import cond_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      force_ccm,
  input  logic      run_done,
  input  logic      smp_pos,
  output arb_mode_e mode_q,
  output arb_mode_e mode_d,
  output logic      flip
);
  // A run flips the mode only when its polarity points away from it:
  // negative leaves continuous, positive leaves hysteretic.
  assign flip = !force_ccm && run_done && (smp_pos == (mode_q == MODE_HYST));

  always_comb begin
    mode_d = mode_q;
    if (force_ccm)  mode_d = MODE_CCM;
    else if (flip)  mode_d = (mode_q == MODE_HYST) ? MODE_CCM : MODE_HYST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_CCM;
    else        mode_q <= mode_d;
  end

  // R6 R7
  force_ccm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_ccm |=> (mode_q == MODE_CCM));

  // R2 R3
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ccm && !run_done) |=> $stable(mode_q));
endmodule

// File: rtl/arb_hyst_pulse.sv
module arb_hyst_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic hyst_next,
  input  logic below_lo,
  input  logic above_hi,
  output logic pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulse_q <= 1'b0;
    else if (!hyst_next) pulse_q <= 1'b0;
    else if (above_hi)   pulse_q <= 1'b0;
    else if (below_lo)   pulse_q <= 1'b1;
  end

  // R9
  hi_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    above_hi |=> !pulse_q);
endmodule

// File: rtl/cond_mode_arbiter.sv
module cond_mode_arbiter #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic smp_pos,
  input  logic hyst_en,
  input  logic ref_slewing,
  input  logic cmp_below_lo,
  input  logic cmp_above_hi,
  output logic mode_hyst,
  output logic diode_emu_en,
  output logic hyst_pulse_req
);
  import cond_mode_pkg::*;
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic             force_ccm;
  logic             run_done;
  logic             flip;
  logic [CNT_W-1:0] run_cnt;
  arb_mode_e        mode_q;
  arb_mode_e        mode_d;

  assign force_ccm = !hyst_en || ref_slewing;

  arb_sign_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_pos  (smp_pos),
    .clr      (force_ccm || flip),
    .run_done (run_done),
    .run_cnt  (run_cnt)
  );

  arb_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_ccm (force_ccm),
    .run_done  (run_done),
    .smp_pos   (smp_pos),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .flip      (flip)
  );

  arb_hyst_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .hyst_next(mode_d == MODE_HYST),
    .below_lo (cmp_below_lo),
    .above_hi (cmp_above_hi),
    .pulse_q  (hyst_pulse_req)
  );

  assign mode_hyst    = (mode_q == MODE_HYST);
  assign diode_emu_en = mode_hyst;

  // R11
  flip_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (run_cnt == '0));

  // R10
  pulse_in_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hyst_pulse_req |-> diode_emu_en);
endmodule

// File: tb/sim_cond_mode_arbiter.sv
module sim_cond_mode_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 0, smp_pos = 0, hyst_en = 1, ref_slewing = 0;
  logic cmp_below_lo = 0, cmp_above_hi = 0;
  logic mode_hyst, diode_emu_en, hyst_pulse_req;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  mode;
    logic  pulse;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench model
  int   m_cnt = 0;
  logic m_sign = 0;
  logic m_mode = 0;
  logic m_pulse = 0;

  cond_mode_arbiter #(.RUN_LEN(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_pos(smp_pos),
    .hyst_en(hyst_en), .ref_slewing(ref_slewing),
    .cmp_below_lo(cmp_below_lo), .cmp_above_hi(cmp_above_hi),
    .mode_hyst(mode_hyst), .diode_emu_en(diode_emu_en),
    .hyst_pulse_req(hyst_pulse_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus at the falling edge and pushes
  // the outputs expected after the following rising edge
  task automatic step(logic vld, logic pos, logic en, logic slew,
                      logic lo, logic hi, string tag);
    logic frc;
    exp_t e;
    @(negedge clk);
    smp_vld = vld; smp_pos = pos; hyst_en = en; ref_slewing = slew;
    cmp_below_lo = lo; cmp_above_hi = hi;
    frc = !en || slew;
    if (frc) begin
      m_mode = 0; m_cnt = 0;
    end else if (vld && m_cnt == RUN-1 && pos == m_sign && pos == m_mode) begin
      m_mode = !m_mode; m_cnt = 0;
    end else if (vld) begin
      if (m_cnt != 0 && pos == m_sign) m_cnt = (m_cnt < RUN) ? m_cnt + 1 : RUN;
      else begin m_cnt = 1; m_sign = pos; end
    end
    if (!m_mode)  m_pulse = 0;
    else if (hi)  m_pulse = 0;
    else if (lo)  m_pulse = 1;
    e.mode = m_mode; e.pulse = m_pulse; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic samples(int n, logic pos, string tag);
    for (int i = 0; i < n; i++) step(1, pos, 1, 0, 0, 0, tag);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, mode_hyst, e.mode, "mode_hyst");
        chk("R8", diode_emu_en, e.mode, "diode_emu_en");
        chk(e.tag, hyst_pulse_req, e.pulse, "hyst_pulse_req");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", mode_hyst, 0, "mode_hyst in reset");
    chk("R1", hyst_pulse_req, 0, "pulse in reset");
    @(negedge clk); rst_n = 1;
    step(0, 0, 1, 0, 0, 0, "R1");

    // R2: seven negatives stay, the eighth switches
    samples(RUN-1, 0, "R2");
    samples(1, 0, "R2");
    // R9: pulse set, hold, clear, clear wins
    step(0, 0, 1, 0, 1, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 1, "R9");
    step(0, 0, 1, 0, 1, 1, "R9");
    step(0, 0, 1, 0, 1, 0, "R9");
    // R4: seven positives, one negative, then seven positives: stays
    samples(RUN-1, 1, "R4");
    samples(1, 0, "R4");
    samples(RUN-1, 1, "R4");
    // R5: idle cycles inside a run do not break it; eighth positive leaves
    step(0, 1, 1, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, "R5");
    // R10: pulse held while leaving hysteretic must drop
    step(0, 0, 1, 0, 1, 0, "R10");
    samples(1, 1, "R3");
    step(0, 0, 1, 0, 1, 0, "R10");
    // R11: back into hysteretic, then a fresh positive run is needed
    samples(RUN-3, 1, "R11");
    samples(RUN, 0, "R11");
    samples(RUN-1, 1, "R11");
    samples(1, 1, "R3");
    // R6: enter hysteretic, then hysteretic disabled
    samples(RUN, 0, "R2");
    step(0, 0, 1, 0, 1, 0, "R9");
    step(1, 0, 0, 0, 1, 0, "R6");
    samples(RUN, 0, "R6");
    for (int i = 0; i < RUN; i++) step(1, 0, 0, 0, 0, 0, "R6");
    samples(RUN-1, 0, "R6");
    // R7: slewing clears a nearly complete run, forces continuous mode
    step(1, 0, 1, 1, 0, 0, "R7");
    samples(RUN-1, 0, "R7");
    samples(1, 0, "R2");
    step(1, 1, 1, 1, 1, 0, "R7");
    for (int i = 0; i < RUN; i++) step(1, 0, 1, 1, 1, 0, "R7");
    step(0, 0, 1, 0, 1, 0, "R10");
    step(0, 0, 1, 0, 0, 0, "R10");
    // drain the scoreboard
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule